// File: doc/BRIEF.md
# Video Field Flag Generator

This block drives the field flag (F) that rides inside the timing reference codes of a 10-bit digital video display stream, and emits those codes itself. Software programs two line numbers in one control word: a "field-two line" and a "field-one line". At each start-of-line strobe, the block compares the incoming frame line count with both numbers. On a match it moves F to 1 or to 0. F then holds across the end-of-active-video (EAV) code that opens the line, across the start-of-active-video (SAV) code later in the same line, and across every later line until the next match. The field output pin of the display port plays no part in this logic. Interlaced and progressive formats are therefore both covered: for progressive output, the field-two line is programmed above the frame height, so F never leaves 0.

Each code is four 10-bit words on consecutive cycles: an all-ones preamble word, two all-zero words, then a status word. The status word carries F, the vertical-blanking flag V (an input), H (1 for EAV, 0 for SAV) and four protection bits. A small state machine steps through the words with the states IDLE, PRE_ONES, PRE_ZERO_A, PRE_ZERO_B and STATUS_WORD. Its transitions are as follows. From IDLE, a start-of-line strobe or an SAV request moves it to PRE_ONES. PRE_ONES moves unconditionally to PRE_ZERO_A, then to PRE_ZERO_B, then to STATUS_WORD, and STATUS_WORD returns to IDLE. A raw-data mode input turns the whole function off.

Top module: `field_flag_gen`

## Requirements
- R1: After reset, `field_f` is 0, `code_valid` is 0, and the control word reads back as 0.
- R2: In the control word, bits 27:16 hold the field-two line and bits 11:0 hold the field-one line. Bits 31:28 and 15:12 always read 0, and writes to them are discarded.
- R3: When `sol` is sampled high and `line_cnt` equals the field-one line, F becomes 0. This change shows in the status word of the EAV that the strobe starts.
- R4: When `sol` is sampled high and `line_cnt` equals the field-two line (and not the field-one line), F becomes 1 from that line's EAV.
- R5: If both programmed lines equal `line_cnt` at a strobe, the field-one line wins and F becomes 0.
- R6: F changes only on a clock edge where `sol` is sampled high. A control-word write made partway through a line leaves the F carried by that line's SAV unchanged; it acts from the next strobe.
- R7: A `sol` accepted in IDLE produces, starting on the next cycle, the words 0x3FF, 0x000, 0x000 and then the status word, one per cycle, with `code_valid` high. The status word has H = 1.
- R8: An `sav_req` accepted in IDLE produces the same four-word pattern with H = 0, carrying the F held since the last EAV.
- R9: The status word has this layout, from bit 9 down to bit 0: 1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0. V is the value of `v_flag` sampled with the request.
- R10: While `raw_mode` is high: `field_f` reads 0, no code words are produced, and strobes leave the internal F unchanged. When raw mode ends, the previous F shows again.
- R11: With the field-two line programmed above every line count that occurs, F stays 0 through any number of lines.
- R12: Requests that arrive while a code is being emitted are dropped. If `sol` and `sav_req` arrive together in IDLE, an EAV is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_mode | input | 1 | High disables the F logic and code emission |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word read-back |
| line_cnt | input | 12 | Frame line count of the line now starting |
| sol | input | 1 | Start-of-line strobe; requests an EAV |
| sav_req | input | 1 | Requests an SAV code |
| v_flag | input | 1 | Vertical blanking flag for the requested code |
| field_f | output | 1 | Current field flag |
| code_word | output | 10 | Timing reference word |
| code_valid | output | 1 | `code_word` carries a code word this cycle |

## Verification
The bench goes after the priority case where both programmed lines match the same line count. A design with the wrong priority would report field two there. It checks that a field-one-line write made partway through a line leaves that line's SAV alone; a design that compared continuously would flip F between EAV and SAV. Raw mode is checked both during and after its use: a design that kept updating F there would come back with F cleared. Requests made during a code, and simultaneous `sol`/`sav_req` pulses, are also covered. A design that restarted or merged sequences would show extra preamble words or H = 0 on what must be an EAV.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
    localparam int LINE_W  = 12;
    localparam int WORD_W  = 10;
    localparam int CFG_W   = 32;
    localparam int SET_LSB = 16;

    typedef enum logic [2:0] {
        IDLE,
        PRE_ONES,
        PRE_ZERO_A,
        PRE_ZERO_B,
        STATUS_WORD
    } seq_state_t;

    function automatic logic [WORD_W-1:0] status_word(input logic f, input logic v, input logic h);
        status_word = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction
endpackage

// File: rtl/ffg_regs.sv
module ffg_regs
    import ffg_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic [LW-1:0]    set_line,
    output logic [LW-1:0]    clr_line
);
    localparam int SET_MSB = SET_LSB + LW - 1;
    localparam int PAD_HI  = CFG_W - SET_LSB - LW;
    localparam int PAD_LO  = SET_LSB - LW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_line <= '0;
            clr_line <= '0;
        end else if (wr_en) begin
            set_line <= wr_data[SET_MSB:SET_LSB];
            clr_line <= wr_data[LW-1:0];
        end
    end

    always_comb begin
        rd_data = {{PAD_HI{1'b0}}, set_line, {PAD_LO{1'b0}}, clr_line};
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CFG_W-1:SET_MSB+1] == '0) && (rd_data[SET_LSB-1:LW] == '0));
endmodule

// File: rtl/ffg_flag.sv
module ffg_flag
    import ffg_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_mode,
    input  logic          sol,
    input  logic [LW-1:0] line_cnt,
    input  logic [LW-1:0] set_line,
    input  logic [LW-1:0] clr_line,
    output logic          f_q
);
    logic upd;
    logic f_next;

    always_comb begin
        upd    = sol && !raw_mode;
        f_next = f_q;
        if (line_cnt == clr_line)      f_next = 1'b0;
        else if (line_cnt == set_line) f_next = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   f_q <= 1'b0;
        else if (upd) f_q <= f_next;
    end

    // R6
    f_only_at_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(f_q) |-> ($past(sol) && !$past(raw_mode)));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sol && !raw_mode && line_cnt == clr_line) |=> !f_q);

    // R10
    raw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_mode |=> $stable(f_q));
endmodule

// File: rtl/ffg_seq.sv
module ffg_seq
    import ffg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              sol,
    input  logic              sav_req,
    input  logic              v_flag,
    input  logic              f_cur,
    output logic [WORD_W-1:0] code_word,
    output logic              code_valid
);
    seq_state_t state, state_nx;
    logic       h_q, v_q;
    logic       start;

    always_comb begin
        start = (sol || sav_req) && !raw_mode;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:        if (start) state_nx = PRE_ONES;
            PRE_ONES:    state_nx = PRE_ZERO_A;
            PRE_ZERO_A:  state_nx = PRE_ZERO_B;
            PRE_ZERO_B:  state_nx = STATUS_WORD;
            STATUS_WORD: state_nx = IDLE;
            default:     state_nx = IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IDLE;
            h_q   <= 1'b0;
            v_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == IDLE && start) begin
                h_q <= sol;
                v_q <= v_flag;
            end
        end
    end

    always_comb begin
        code_word  = '0;
        code_valid = 1'b1;
        unique case (state)
            IDLE:        code_valid = 1'b0;
            PRE_ONES:    code_word  = '1;
            PRE_ZERO_A:  code_word  = '0;
            PRE_ZERO_B:  code_word  = '0;
            STATUS_WORD: code_word  = status_word(f_cur, v_q, h_q);
            default:     code_valid = 1'b0;
        endcase
    end

    // R7
    preamble_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_word == '1) |=> (code_valid && code_word == '0));

    // R12
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_word == '1) |=> ##1 (code_valid && code_word == '0));
endmodule

// File: rtl/field_flag_gen.sv
module field_flag_gen
    import ffg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              sol,
    input  logic              sav_req,
    input  logic              v_flag,
    output logic              field_f,
    output logic [WORD_W-1:0] code_word,
    output logic              code_valid
);
    logic [LINE_W-1:0] set_line, clr_line;
    logic              f_q;

    ffg_regs #(.LW(LINE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .set_line (set_line),
        .clr_line (clr_line)
    );

    ffg_flag #(.LW(LINE_W)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_mode (raw_mode),
        .sol      (sol),
        .line_cnt (line_cnt),
        .set_line (set_line),
        .clr_line (clr_line),
        .f_q      (f_q)
    );

    ffg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_mode   (raw_mode),
        .sol        (sol),
        .sav_req    (sav_req),
        .v_flag     (v_flag),
        .f_cur      (f_q),
        .code_word  (code_word),
        .code_valid (code_valid)
    );

    always_comb begin
        field_f = f_q && !raw_mode;
    end

    // R9
    status_f_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_word[WORD_W-1] && code_word[1:0] == 2'b00 && !raw_mode)
            |-> (code_word[WORD_W-2] == field_f));
endmodule

// File: tb/sim_field_flag_gen.sv
module sim_field_flag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_mode = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [11:0] line_cnt = '0;
    logic        sol = 1'b0;
    logic        sav_req = 1'b0;
    logic        v_flag = 1'b0;
    logic        field_f;
    logic [9:0]  code_word;
    logic        code_valid;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    field_flag_gen u0 (
        .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .line_cnt(line_cnt), .sol(sol), .sav_req(sav_req), .v_flag(v_flag),
        .field_f(field_f), .code_word(code_word), .code_valid(code_valid)
    );

    // {field-two line, field-one line, line count, V, expected F}
    localparam int NV = 8;
    localparam logic [37:0] VEC [NV] = '{
        {12'd5,    12'd1, 12'd3, 1'b0, 1'b0},
        {12'd5,    12'd1, 12'd5, 1'b1, 1'b1},
        {12'd5,    12'd1, 12'd6, 1'b0, 1'b1},
        {12'd5,    12'd1, 12'd1, 1'b1, 1'b0},
        {12'd7,    12'd2, 12'd7, 1'b0, 1'b1},
        {12'd9,    12'd9, 12'd9, 1'b1, 1'b0},
        {12'd4095, 12'd0, 12'd3, 1'b0, 1'b0},
        {12'd4095, 12'd0, 12'd0, 1'b1, 1'b0}
    };

    function automatic logic [9:0] exp_xy(input logic f, input logic v, input logic h);
        logic [9:0] w;
        w[9] = 1'b1; w[8] = f; w[7] = v; w[6] = h;
        w[5] = v ^ h; w[4] = f ^ h; w[3] = f ^ v; w[2] = f ^ v ^ h;
        w[1:0] = 2'b00;
        return w;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [11:0] setl, input logic [11:0] clrl);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = {4'h0, setl, 4'h0, clrl};
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic run_code(input bit eav, input logic [11:0] line, input bit v,
                            input bit ef, input string req);
        @(negedge clk);
        line_cnt = line; v_flag = v;
        if (eav) sol = 1'b1; else sav_req = 1'b1;
        @(negedge clk);
        sol = 1'b0; sav_req = 1'b0;
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, 10'h3FF}, req);
        @(negedge clk);
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, 10'h000}, req);
        @(negedge clk);
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, 10'h000}, req);
        @(negedge clk);
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, exp_xy(ef, v, eav)}, req);
        chk({31'd0, field_f}, {31'd0, ef}, req);
        @(negedge clk);
        chk({31'd0, code_valid}, 32'd0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({31'd0, field_f}, 32'd0, "R1 field_f");
        chk({31'd0, code_valid}, 32'd0, "R1 code_valid");
        chk(cfg_rd_data, 32'd0, "R1 cfg_rd_data");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reserved bits discarded, fields in place
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = 32'hFABC_FDEF;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk(cfg_rd_data, 32'h0ABC_0DEF, "R2 layout");

        // table walk: R3 R4 R5 R9 R11 via EAV, R8 via SAV of each line
        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i][37:26], VEC[i][25:14]);
            run_code(1'b1, VEC[i][13:2], VEC[i][1], VEC[i][0], "R3/R4/R5/R7 EAV vector");
            run_code(1'b0, VEC[i][13:2], ~VEC[i][1], VEC[i][0], "R8 SAV vector");
        end

        // R11 progressive: many lines, F stays 0
        write_cfg(12'd4095, 12'd0);
        for (int l = 1; l < 30; l++) begin
            @(negedge clk); line_cnt = l[11:0]; sol = 1'b1;
            @(negedge clk); sol = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk({31'd0, field_f}, 32'd0, "R11 progressive");

        // R6 mid-line write does not alter this line's SAV
        write_cfg(12'd20, 12'd0);
        run_code(1'b1, 12'd20, 1'b0, 1'b1, "R4 set line 20");
        write_cfg(12'd30, 12'd20);
        run_code(1'b0, 12'd20, 1'b0, 1'b1, "R6 SAV after mid-line write");
        run_code(1'b1, 12'd21, 1'b0, 1'b1, "R6 hold on non-matching line");
        run_code(1'b1, 12'd20, 1'b1, 1'b0, "R3 clear at next strobe");

        // R10 raw mode
        write_cfg(12'd40, 12'd41);
        run_code(1'b1, 12'd40, 1'b0, 1'b1, "R4 set line 40");
        @(negedge clk); raw_mode = 1'b1;
        @(negedge clk);
        chk({31'd0, field_f}, 32'd0, "R10 field_f in raw");
        line_cnt = 12'd41; sol = 1'b1;
        @(negedge clk); sol = 1'b0;
        chk({31'd0, code_valid}, 32'd0, "R10 no EAV in raw");
        sav_req = 1'b1;
        @(negedge clk); sav_req = 1'b0;
        chk({31'd0, code_valid}, 32'd0, "R10 no SAV in raw");
        @(negedge clk); raw_mode = 1'b0;
        @(negedge clk);
        chk({31'd0, field_f}, 32'd1, "R10 F frozen");

        // R12 request during emission dropped
        @(negedge clk); line_cnt = 12'd50; sol = 1'b1;
        @(negedge clk); sol = 1'b0; sav_req = 1'b1;
        @(negedge clk); sav_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, exp_xy(1'b1, 1'b0, 1'b1)}, "R12 status of EAV");
        @(negedge clk);
        chk({31'd0, code_valid}, 32'd0, "R12 dropped request");

        // R12 simultaneous sol and sav_req -> EAV
        @(negedge clk); line_cnt = 12'd51; sol = 1'b1; sav_req = 1'b1; v_flag = 1'b1;
        @(negedge clk); sol = 1'b0; sav_req = 1'b0;
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, 10'h3FF}, "R12 simultaneous start");
        repeat (3) @(negedge clk);
        chk({21'd0, code_valid, code_word}, {21'd0, 1'b1, exp_xy(1'b1, 1'b1, 1'b1)}, "R12 simultaneous H");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule